// File: doc/BRIEF.md
# Phase Bisection Search Engine

This block turns the two correlation sums of a fringe profile (the sine-weighted sum `Is` and the cosine-weighted sum `Ic`) and the estimated fringe amplitude `amp` into a discretised phase. The phase circle [−π, π) is split into `N_NODES` equally spaced nodes. For every node `k` the block holds three signed fixed-point tables: sin θk, cos θk and a per-node amplitude correction term `A[k]`. The node angle is θk = −π + 2πk/N_NODES. Software or a neighbouring generator fills the tables through a simple write port; this block does not compute them.

On a start pulse the engine latches the three inputs. It then runs a fixed-length dichotomous search for a sign change of the residual v(k) = 2·(Is·cos[k] + Ic·sin[k]) − amp·A[k]. It narrows a bracket [left, right] until the bracket is one node wide. It then reports whichever of the two bracketing nodes better zeroes the residual. The result is given both as a node index and as a fixed-point angle in radians, qualified by a one-cycle done pulse. Because every search takes the same number of evaluations, the result latency is constant. This lets a streaming pipeline upstream schedule one profile per search slot.

Top module: `phsrch_top`

## Requirements
- R1: While and after synchronous active-high reset, `done` is 0, `idx` is 0 and `phase` is 0 until the first search completes.
- R2: A write with `tbl_we`=1 stores `tbl_data` at node `tbl_addr` of the table chosen by `tbl_sel`: 0 selects sin θ, 1 selects cos θ, 2 selects the amplitude term A. Table entries use the scale U = 2^(TW−2) for 1.0.
- R3: The first bracket value is v_l = −2·Is·U − amp·A[0]. It is formed from A[0] only and does not read sin[0] or cos[0].
- R4: The search starts with left = 0 and step = right = N_NODES/2. While step ≥ 1 it evaluates v(right). If not (v_l < 0 and v(right) ≥ 0), left and v_l take right and v(right). The step then halves and right becomes left + step.
- R5: After the loop, right = min(left + 1, N_NODES − 1) and v_r = v(right). When left reaches N_NODES−1 the right node clamps there.
- R6: The result index is left when |v_l| < v_r (signed compare of v_r), otherwise right; a tie selects right.
- R7: `phase` = floor((2·idx − N_NODES)·round(π·2^PF) / N_NODES), in units of 2^−PF rad. Index 0 gives −π and index N_NODES/2 gives 0.
- R8: `done` is a single-cycle pulse. It is high in the cycle that begins 4·(log2 N_NODES + 2) + 1 rising edges after the edge that samples `start` (49 for the defaults). `idx` and `phase` change only together with `done` and hold otherwise.
- R9: `start`, `is_in`, `ic_in` and `amp_in` are sampled only when the engine is idle. A start pulse or input change during a search does not alter its result and produces no extra `done`.
- R10: Each residual uses v(k) = 2·(Is·cos[k] + Ic·sin[k]) − amp·A[k] with the stored table entries, evaluated exactly in integer arithmetic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 2 | Table select: 0 sin, 1 cos, 2 amplitude term |
| tbl_addr | input | LW | Node index for a table write |
| tbl_data | input | TW | Signed table entry |
| start | input | 1 | Begin a search (honoured only when idle) |
| is_in | input | IW | Signed sine-weighted correlation sum |
| ic_in | input | IW | Signed cosine-weighted correlation sum |
| amp_in | input | AW | Signed fringe amplitude |
| done | output | 1 | One-cycle result strobe |
| idx | output | LW | Selected phase node index |
| phase | output | PW | Signed phase, 2^−PF rad per unit |

## Verification
Realistic tables rarely drive the search into its edges. It is hard to make every comparison fail so that left walks to the last node and the final right node must clamp. It is equally hard to show that the first value ignores the sin and cos entries of node 0. The bench reaches both by overwriting all three tables with degenerate contents: all-negative residuals for the clamp, and a poisoned cos[0] for the initial value. It then loads a table set that gives an exact |v_l| = v_r tie. It also re-pulses start with different inputs in the middle of a search to show that the running search is unaffected.

// File: rtl/phsrch_pkg.sv
package phsrch_pkg;

    // Controller phases of a search
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_PICK
    } st_e;

    // What the in-flight evaluation is for
    typedef enum logic [1:0] {
        EV_INIT,
        EV_LOOP,
        EV_POST
    } ev_e;

    // Table select encoding on the write port
    localparam logic [1:0] TSEL_SIN = 2'd0;
    localparam logic [1:0] TSEL_COS = 2'd1;
    localparam logic [1:0] TSEL_AMP = 2'd2;

    localparam real PI_R = 3.14159265358979;

    // round(pi * 2^frac)
    function automatic int unsigned pi_fixed(input int unsigned frac);
        return $rtoi(PI_R * (2.0 ** frac) + 0.5);
    endfunction

endpackage

// File: rtl/phsrch_tables.sv
module phsrch_tables
    import phsrch_pkg::*;
#(
    parameter int N_NODES = 1024,
    parameter int TW      = 16,
    localparam int LW     = $clog2(N_NODES)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [1:0]           sel,
    input  logic [LW-1:0]        waddr,
    input  logic signed [TW-1:0] wdata,
    input  logic [LW-1:0]        raddr,
    output logic signed [TW-1:0] rd_sin,
    output logic signed [TW-1:0] rd_cos,
    output logic signed [TW-1:0] rd_amp
);

    // One simple dual-port array per table, registered read
    for (genvar g = 0; g < 3; g++) begin : g_tbl
        logic signed [TW-1:0] mem [N_NODES];
        logic signed [TW-1:0] q;
        always_ff @(posedge clk) begin
            if (we && (sel == 2'(g)))
                mem[waddr] <= wdata;
            q <= mem[raddr];
        end
    end

    assign rd_sin = g_tbl[TSEL_SIN].q;
    assign rd_cos = g_tbl[TSEL_COS].q;
    assign rd_amp = g_tbl[TSEL_AMP].q;

endmodule

// File: rtl/phsrch_eval.sv
module phsrch_eval #(
    parameter int IW = 24,
    parameter int AW = 16,
    parameter int TW = 16,
    parameter int VW = 42
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue,
    input  logic                 init_mode,
    input  logic signed [IW-1:0] is_q,
    input  logic signed [IW-1:0] ic_q,
    input  logic signed [AW-1:0] amp_q,
    input  logic signed [TW-1:0] rd_sin,
    input  logic signed [TW-1:0] rd_cos,
    input  logic signed [TW-1:0] rd_amp,
    output logic signed [VW-1:0] v,
    output logic                 v_valid
);

    // -1.0 in table scale: forced cosine of node 0 for the first value
    localparam logic signed [TW-1:0] NEG_UNIT = TW'(-(2 ** (TW - 2)));

    logic                 vld1, vld2, ini1;
    logic signed [TW-1:0] c_use, s_use;
    logic signed [VW-1:0] pc, ps, pa;

    always_comb begin
        c_use = ini1 ? NEG_UNIT : rd_cos;
        s_use = ini1 ? '0 : rd_sin;
    end

    // Valid pipe: issue (table read) -> products -> residual
    always_ff @(posedge clk) begin
        if (rst) begin
            vld1    <= 1'b0;
            vld2    <= 1'b0;
            v_valid <= 1'b0;
            ini1    <= 1'b0;
        end else begin
            vld1    <= issue;
            ini1    <= init_mode;
            vld2    <= vld1;
            v_valid <= vld2;
        end
    end

    always_ff @(posedge clk) begin
        pc <= VW'(is_q)  * VW'(c_use);
        ps <= VW'(ic_q)  * VW'(s_use);
        pa <= VW'(amp_q) * VW'(rd_amp);
        v  <= ((pc + ps) <<< 1) - pa;
    end

endmodule

// File: rtl/phsrch_ctrl.sv
module phsrch_ctrl
    import phsrch_pkg::*;
#(
    parameter int N_NODES = 1024,
    parameter int IW      = 24,
    parameter int AW      = 16,
    parameter int VW      = 42,
    parameter int PW      = 16,
    parameter int PF      = 13,
    localparam int LW     = $clog2(N_NODES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic signed [IW-1:0] is_in,
    input  logic signed [IW-1:0] ic_in,
    input  logic signed [AW-1:0] amp_in,
    output logic signed [IW-1:0] is_q,
    output logic signed [IW-1:0] ic_q,
    output logic signed [AW-1:0] amp_q,
    output logic [LW-1:0]        rd_addr,
    output logic                 issue,
    output logic                 init_mode,
    input  logic signed [VW-1:0] v,
    input  logic                 v_valid,
    output logic                 done,
    output logic [LW-1:0]        idx,
    output logic signed [PW-1:0] phase,
    output logic                 busy,
    output logic [LW-1:0]        left_o,
    output logic [LW-1:0]        right_o,
    output logic [LW-1:0]        step_o
);

    localparam logic [LW-1:0] MAX_IDX = LW'(N_NODES - 1);
    localparam logic [LW-1:0] HALF    = LW'(N_NODES / 2);
    localparam int            PRW     = LW + PF + 4;
    localparam logic signed [PRW-1:0] PI_Q = PRW'(pi_fixed(PF));

    st_e  state;
    ev_e  kind;
    logic [LW-1:0]        left, right, step;
    logic signed [VW-1:0] v_l, v_r;

    // Bracket update terms for a loop evaluation
    logic                 bracket_ok;
    logic [LW-1:0]        new_left, step_n, next_clamped;
    logic [LW:0]          inc;

    always_comb begin
        bracket_ok   = (v_l < 0) && (v >= 0);
        new_left     = bracket_ok ? left : right;
        step_n       = step >> 1;
        inc          = {1'b0, new_left} + (LW + 1)'(1);
        next_clamped = (inc > (LW + 1)'(N_NODES - 1)) ? MAX_IDX : inc[LW-1:0];
    end

    // Final choice between the two bracketing nodes
    logic signed [VW:0]    vl_x, vr_x, vl_abs;
    logic [LW-1:0]         pick_idx;
    logic signed [LW+1:0]  diff;
    logic signed [PRW-1:0] prod;
    logic signed [PW-1:0]  phase_n;

    always_comb begin
        vl_x     = (VW + 1)'(v_l);
        vr_x     = (VW + 1)'(v_r);
        vl_abs   = (vl_x < 0) ? -vl_x : vl_x;
        pick_idx = (vl_abs < vr_x) ? left : right;
        diff     = $signed({1'b0, pick_idx, 1'b0}) - $signed((LW + 2)'(N_NODES));
        prod     = PRW'(diff) * PI_Q;
        phase_n  = PW'(prod >>> LW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            kind  <= EV_INIT;
            left  <= '0;
            right <= '0;
            step  <= '0;
            v_l   <= '0;
            v_r   <= '0;
            is_q  <= '0;
            ic_q  <= '0;
            amp_q <= '0;
            done  <= 1'b0;
            idx   <= '0;
            phase <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        is_q  <= is_in;
                        ic_q  <= ic_in;
                        amp_q <= amp_in;
                        left  <= '0;
                        right <= '0;
                        step  <= '0;
                        kind  <= EV_INIT;
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (v_valid) begin
                        case (kind)
                            EV_INIT: begin
                                v_l   <= v;
                                right <= HALF;
                                step  <= HALF;
                                kind  <= EV_LOOP;
                                state <= ST_ISSUE;
                            end
                            EV_LOOP: begin
                                v_r <= v;
                                if (!bracket_ok) begin
                                    left <= right;
                                    v_l  <= v;
                                end
                                step <= step_n;
                                if (step_n == '0) begin
                                    right <= next_clamped;
                                    kind  <= EV_POST;
                                end else begin
                                    right <= new_left + step_n;
                                end
                                state <= ST_ISSUE;
                            end
                            EV_POST: begin
                                v_r   <= v;
                                state <= ST_PICK;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
                ST_PICK: begin
                    idx   <= pick_idx;
                    phase <= phase_n;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_addr   = right;
    assign issue     = (state == ST_ISSUE);
    assign init_mode = (kind == EV_INIT);
    assign busy      = (state != ST_IDLE);
    assign left_o    = left;
    assign right_o   = right;
    assign step_o    = step;

endmodule

// File: rtl/phsrch_top.sv
module phsrch_top
    import phsrch_pkg::*;
#(
    parameter int N_NODES = 1024,
    parameter int IW      = 24,
    parameter int AW      = 16,
    parameter int TW      = 16,
    parameter int PW      = 16,
    parameter int PF      = 13,
    localparam int LW     = $clog2(N_NODES),
    localparam int VW     = ((IW > AW) ? IW : AW) + TW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tbl_we,
    input  logic [1:0]           tbl_sel,
    input  logic [LW-1:0]        tbl_addr,
    input  logic signed [TW-1:0] tbl_data,
    input  logic                 start,
    input  logic signed [IW-1:0] is_in,
    input  logic signed [IW-1:0] ic_in,
    input  logic signed [AW-1:0] amp_in,
    output logic                 done,
    output logic [LW-1:0]        idx,
    output logic signed [PW-1:0] phase
);

    logic signed [IW-1:0] is_q, ic_q;
    logic signed [AW-1:0] amp_q;
    logic [LW-1:0]        rd_addr, left_i, right_i, step_i;
    logic                 issue, init_mode, v_valid, busy;
    logic signed [TW-1:0] rd_sin, rd_cos, rd_amp;
    logic signed [VW-1:0] v;

    phsrch_tables #(.N_NODES(N_NODES), .TW(TW)) u_tables (
        .clk    (clk),
        .we     (tbl_we),
        .sel    (tbl_sel),
        .waddr  (tbl_addr),
        .wdata  (tbl_data),
        .raddr  (rd_addr),
        .rd_sin (rd_sin),
        .rd_cos (rd_cos),
        .rd_amp (rd_amp)
    );

    phsrch_eval #(.IW(IW), .AW(AW), .TW(TW), .VW(VW)) u_eval (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .init_mode (init_mode),
        .is_q      (is_q),
        .ic_q      (ic_q),
        .amp_q     (amp_q),
        .rd_sin    (rd_sin),
        .rd_cos    (rd_cos),
        .rd_amp    (rd_amp),
        .v         (v),
        .v_valid   (v_valid)
    );

    phsrch_ctrl #(
        .N_NODES(N_NODES), .IW(IW), .AW(AW), .VW(VW), .PW(PW), .PF(PF)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .is_in     (is_in),
        .ic_in     (ic_in),
        .amp_in    (amp_in),
        .is_q      (is_q),
        .ic_q      (ic_q),
        .amp_q     (amp_q),
        .rd_addr   (rd_addr),
        .issue     (issue),
        .init_mode (init_mode),
        .v         (v),
        .v_valid   (v_valid),
        .done      (done),
        .idx       (idx),
        .phase     (phase),
        .busy      (busy),
        .left_o    (left_i),
        .right_o   (right_i),
        .step_o    (step_i)
    );

endmodule

// File: rtl/phsrch_check.sv
module phsrch_check #(
    parameter int N_NODES = 1024,
    parameter int IW      = 24,
    parameter int PW      = 16,
    localparam int LW     = $clog2(N_NODES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 done,
    input logic                 busy,
    input logic [LW-1:0]        idx,
    input logic signed [PW-1:0] phase,
    input logic [LW-1:0]        left_i,
    input logic [LW-1:0]        right_i,
    input logic [LW-1:0]        step_i,
    input logic signed [IW-1:0] is_q
);

    // R8: result strobe lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: outputs move only together with the strobe
    p_hold_outputs_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(idx) && $stable(phase)));

    // R9: a start during a search leaves latched inputs alone
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(is_q));

    // R4: bisection step is zero or a single power of two
    p_step_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> $onehot0(step_i));

    // R4: while stepping, the right node lies beyond the left node
    p_bracket_order_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && (step_i != '0)) |-> (right_i > left_i));

    // R6: reported node is one of the two bracketing nodes
    p_pick_bracket_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> ((idx == left_i) || (idx == right_i)));

    // R7: lower half of the nodes maps to negative angles
    p_phase_sign_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> ((phase < 0) == (idx < LW'(N_NODES / 2))));

endmodule

bind phsrch_top phsrch_check #(.N_NODES(N_NODES), .IW(IW), .PW(PW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .busy    (busy),
    .idx     (idx),
    .phase   (phase),
    .left_i  (left_i),
    .right_i (right_i),
    .step_i  (step_i),
    .is_q    (is_q)
);

// File: tb/sim_phsrch_top.sv
`timescale 1ns/1ps
module sim_phsrch_top;

    localparam int N    = 1024;
    localparam int LW   = 10;
    localparam int IW   = 24;
    localparam int AW   = 16;
    localparam int TW   = 16;
    localparam int PW   = 16;
    localparam longint UNIT = 16384;      // 2^(TW-2)
    localparam longint PIQ  = 25736;      // round(pi * 2^13)
    localparam int     LAT  = 4 * (LW + 2) + 1;
    localparam real    PI   = 3.14159265358979;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 tbl_we = 1'b0;
    logic [1:0]           tbl_sel = '0;
    logic [LW-1:0]        tbl_addr = '0;
    logic signed [TW-1:0] tbl_data = '0;
    logic                 start = 1'b0;
    logic signed [IW-1:0] is_in = '0;
    logic signed [IW-1:0] ic_in = '0;
    logic signed [AW-1:0] amp_in = '0;
    logic                 done;
    logic [LW-1:0]        idx;
    logic signed [PW-1:0] phase;

    always #2 clk = ~clk;   // 250 MHz

    phsrch_top u0 (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data), .start(start),
        .is_in(is_in), .ic_in(ic_in), .amp_in(amp_in),
        .done(done), .idx(idx), .phase(phase)
    );

    int n_chk = 0;
    int n_fail = 0;
    int done_cnt = 0;

    longint ts [N];   // sin table model
    longint tc [N];   // cos table model
    longint ta [N];   // amplitude term model

    always @(negedge clk) if (done === 1'b1) done_cnt++;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint rnd(input real x);
        return (x >= 0.0) ? longint'($rtoi(x + 0.5)) : -longint'($rtoi(-x + 0.5));
    endfunction

    function automatic longint resid(input int k, input longint a_is, a_ic, a_amp);
        return 2 * (a_is * tc[k] + a_ic * ts[k]) - a_amp * ta[k];
    endfunction

    // Search as the requirements state it (R3..R6)
    function automatic int ref_search(input longint a_is, a_ic, a_amp);
        int     stp = N / 2;
        int     l = 0;
        int     r = stp;
        longint vl = -2 * a_is * UNIT - a_amp * ta[0];
        longint vr = 0;
        longint avl;
        while (stp >= 1) begin
            vr = resid(r, a_is, a_ic, a_amp);
            if (!(vl < 0 && vr >= 0)) begin
                vl = vr;
                l  = r;
            end
            stp = stp / 2;
            r   = l + stp;
        end
        if (!(vl < 0 && vr >= 0)) begin
            vl = vr;
            l  = r;
            r  = (l + 1 > N - 1) ? N - 1 : l + 1;
            vr = resid(r, a_is, a_ic, a_amp);
        end else begin
            r = (l + 1 > N - 1) ? N - 1 : l + 1;
        end
        avl = (vl < 0) ? -vl : vl;
        return (avl < vr) ? l : r;
    endfunction

    function automatic longint ref_phase(input int k);
        longint d = 2 * longint'(k) - N;
        return (d * PIQ) >>> LW;
    endfunction

    // R2: sel 0 = sin, 1 = cos, 2 = amplitude term
    task automatic load_tables();
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < N; k++) begin
                @(negedge clk);
                tbl_we   = 1'b1;
                tbl_sel  = 2'(s);
                tbl_addr = LW'(k);
                tbl_data = TW'((s == 0) ? ts[k] : (s == 1) ? tc[k] : ta[k]);
            end
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic run_search(input longint a_is, a_ic, a_amp, output int lat);
        @(negedge clk);
        is_in  = IW'(a_is);
        ic_in  = IW'(a_ic);
        amp_in = AW'(a_amp);
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = -1;
        for (int n = 1; n <= 200; n++) begin
            @(negedge clk);
            if (done) begin
                lat = n;
                break;
            end
        end
    endtask

    task automatic check_search(input string tag, input longint a_is, a_ic, a_amp);
        int lat;
        int e;
        e = ref_search(a_is, a_ic, a_amp);
        run_search(a_is, a_ic, a_amp, lat);
        chk({tag, " R8 latency"}, lat, LAT);
        chk({tag, " R4 R10 index"}, idx, e);
        chk({tag, " R7 phase"}, phase, ref_phase(e));
        @(negedge clk);
        chk({tag, " R8 single pulse"}, done, 0);
    endtask

    task automatic t_reset();
        chk("R1 done at reset", done, 0);
        chk("R1 idx at reset", idx, 0);
        chk("R1 phase at reset", phase, 0);
    endtask

    task automatic t_profiles();
        for (int k = 0; k < N; k++) begin
            real th = -PI + 2.0 * PI * k / N;
            ts[k] = rnd(real'(UNIT) * $sin(th));
            tc[k] = rnd(real'(UNIT) * $cos(th));
            ta[k] = rnd(4096.0 * ($cos(2.0 * th) * 1.3 - 0.6 * $sin(2.0 * th)));
        end
        load_tables();
        check_search("R2 profile A", 120000, -50000, 3000);
        check_search("R2 profile B", -80000, 90000, 5000);
        check_search("R2 profile C", 5000, 200000, 1200);
        check_search("R2 profile D", -150000, -30000, 800);
    endtask

    // R5: every residual negative, left walks to the last node, right clamps
    task automatic t_clamp();
        for (int k = 0; k < N; k++) begin
            ts[k] = 0; tc[k] = 0; ta[k] = 1;
        end
        load_tables();
        check_search("R5 clamp", 0, 0, 500);
        chk("R5 clamp last node", idx, N - 1);
    endtask

    // R3: cos[0] poisoned; first value must come from A[0] alone
    task automatic t_init_override();
        for (int k = 0; k < N; k++) begin
            ts[k] = 0; tc[k] = 0; ta[k] = -3;
        end
        tc[0] = UNIT;
        ts[0] = UNIT;
        ta[0] = 1;
        load_tables();
        check_search("R3 init value", 1, 0, 20000);
        chk("R3 node zero chosen", idx, 0);
    endtask

    // R6: |v_l| == v_r picks right
    task automatic t_tie();
        for (int k = 0; k < N; k++) begin
            ts[k] = 0; tc[k] = 0; ta[k] = -1;
        end
        ta[0] = 1;
        load_tables();
        check_search("R6 tie", 0, 0, 1000);
        chk("R6 tie picks right node", idx, 1);
    endtask

    // R9: start and new inputs during a search are ignored
    task automatic t_busy();
        int lat;
        int e;
        int base;
        for (int k = 0; k < N; k++) begin
            real th = -PI + 2.0 * PI * k / N;
            ts[k] = rnd(real'(UNIT) * $sin(th));
            tc[k] = rnd(real'(UNIT) * $cos(th));
            ta[k] = rnd(2048.0 * $cos(2.0 * th));
        end
        load_tables();
        e = ref_search(60000, 70000, 2500);
        base = done_cnt;
        @(negedge clk);
        is_in = 60000; ic_in = 70000; amp_in = 2500; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = -1;
        for (int n = 1; n <= 200; n++) begin
            @(negedge clk);
            if (n == 10) begin
                is_in = -90000; ic_in = 10000; amp_in = 4000; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) begin
                lat = n;
                break;
            end
        end
        chk("R9 latency with mid-search start", lat, LAT);
        chk("R9 result from first inputs", idx, e);
        repeat (80) @(negedge clk);
        chk("R9 no extra done", done_cnt - base, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_profiles();
        t_clamp();
        t_init_override();
        t_tie();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule